// File: doc/BRIEF.md
# Key-Protected Sequence Table Store

This block is a register bank holding sixteen command sequences of four 32-bit words each, 64 words in total. A simple single-cycle register interface lets software write and read the table. A separate combinational read port lets a sequence engine fetch any word by sequence index and word index. The engine port does not depend on the bus.

The table is guarded by a lock. While it is locked, table writes are silently dropped. To change the lock state, software writes a magic key to a key register. The very next bus write must then be a command to the lock-control register. Any other write in between disarms the key. The block comes out of reset locked, with sequence 0 preset to a basic read sequence and every other word cleared.

Top module: `seqtab_store`

## Requirements
- R1: After reset the table is locked, the key is disarmed, sequence 0 words 0..3 read 0x08180403, 0x00001C08, 0x00000000, 0x00000000, and every other word reads zero.
- R2: Table word (s, w) sits at byte address 0x100 + 16*s + 4*w. A bus read there returns the same value as the engine port returns for eng_seq = s, eng_word = w.
- R3: While the table is locked, a bus write to a table word leaves the stored value unchanged.
- R4: While the table is unlocked, a bus write to a table word stores bus_wdata there. No other word changes.
- R5: Writing 0x5AF05AF0 to the key register (0x008), followed immediately by a write of value 2 (bit 1 set, bit 0 clear) to the lock-control register (0x00C), unlocks the table.
- R6: Writing the key, followed immediately by a write of value 1 (bit 0 set, bit 1 clear) to the lock-control register, locks the table.
- R7: A lock-control write does nothing if the previous bus write was not the correct key. This covers a wrong key value, a table write, a write to another address, or an earlier command. Reads in between do not disarm the key.
- R8: A lock-control write whose low two bits are 00 or 11 leaves the lock state unchanged, even when the key is armed.
- R9: A bus read of the lock-control register returns 1 in bit 0 while the table is locked and 0 while it is unlocked. All other bits read zero. Reads of the key register and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 10 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| eng_seq | input | 4 | Sequence index for the engine read port |
| eng_word | input | 2 | Word index within the sequence |
| eng_data | output | 32 | Combinational table word for the engine |

## Verification
The hardest state to reach is an armed key followed by something other than a clean command. Two cases matter most: a command with both bits set or neither bit set, and a key write whose command is separated from it by a table write or by reads.

Directed sequences place each of these interleavings explicitly and check the lock bit through the lock-control read. The random phase weights key writes heavily and draws command values over all four low-bit codes. As a result, armed-then-interrupted sequences occur many times, in both the locked and the unlocked state.

// File: rtl/seqtab_store.sv
module seqtab_store #(
  parameter int DW    = 32,
  parameter int NSEQ  = 16,
  parameter int NWORD = 4,
  parameter int AW    = 10,
  parameter logic [AW-1:0] KEY_ADDR = 10'h008,
  parameter logic [AW-1:0] CMD_ADDR = 10'h00C,
  parameter logic [AW-1:0] TBL_BASE = 10'h100,
  parameter logic [DW-1:0] KEY_VAL  = 32'h5AF0_5AF0,
  parameter logic [NWORD*DW-1:0] SEQ0_INIT = {32'h0, 32'h0, 32'h0000_1C08, 32'h0818_0403}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [$clog2(NSEQ)-1:0]  eng_seq,
  input  logic [$clog2(NWORD)-1:0] eng_word,
  output logic [DW-1:0]            eng_data
);
  localparam int SW    = $clog2(NSEQ);
  localparam int WW    = $clog2(NWORD);
  localparam int IW    = SW + WW;
  localparam int DEPTH = NSEQ * NWORD;

  logic [DW-1:0] tbl_q [DEPTH];
  logic locked_q, armed_q;

  wire hit_tbl = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:IW+2] == TBL_BASE[AW-1:IW+2]);
  wire hit_key = (bus_addr == KEY_ADDR);
  wire hit_cmd = (bus_addr == CMD_ADDR);
  wire [IW-1:0] bus_idx = bus_addr[IW+1:2];
  wire key_ok     = bus_wr && hit_key && (bus_wdata == KEY_VAL);
  wire cmd_lock   = bus_wr && hit_cmd && armed_q && (bus_wdata[1:0] == 2'b01);
  wire cmd_unlock = bus_wr && hit_cmd && armed_q && (bus_wdata[1:0] == 2'b10);
  wire tbl_we     = bus_wr && hit_tbl && !locked_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      armed_q <= 1'b0;
    else if (bus_wr) armed_q <= key_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          locked_q <= 1'b1;
    else if (cmd_lock)   locked_q <= 1'b1;
    else if (cmd_unlock) locked_q <= 1'b0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [DW-1:0] RV = (g < NWORD) ? SEQ0_INIT[(g % NWORD)*DW +: DW] : '0;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                            tbl_q[g] <= RV;
      else if (tbl_we && bus_idx == IW'(g))  tbl_q[g] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_tbl)      bus_rdata = tbl_q[bus_idx];
    else if (hit_cmd) bus_rdata = {{(DW-1){1'b0}}, locked_q};
  end

  assign eng_data = tbl_q[{eng_seq, eng_word}];

  a_r1_reset_locked: assert property (@(posedge clk) $rose(rst_n) |-> locked_q && !armed_q);
  a_r2_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tbl && bus_idx == {eng_seq, eng_word}) |-> bus_rdata == eng_data);
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_tbl && locked_q) |=> tbl_q[$past(bus_idx)] == $past(tbl_q[bus_idx]));
  a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cmd && armed_q && bus_wdata[1:0] == 2'b10) |=> !locked_q);
  a_r6_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cmd && armed_q && bus_wdata[1:0] == 2'b01) |=> locked_q);
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(hit_key && bus_wdata == KEY_VAL)) |=> !armed_q);
  a_r7_nokey: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cmd && !armed_q) |=> $stable(locked_q));
  a_r8_badcmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cmd && (bus_wdata[1:0] == 2'b00 || bus_wdata[1:0] == 2'b11)) |=> $stable(locked_q));
endmodule

// File: tb/sim_seqtab_store.sv
module sim_seqtab_store;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, eng_data;
  logic [3:0] eng_seq = '0;
  logic [1:0] eng_word = '0;

  localparam logic [31:0] KEY = 32'h5AF0_5AF0;
  localparam logic [9:0] KADR = 10'h008, CADR = 10'h00C;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [64];
  logic m_locked, m_armed;

  always #2 clk = ~clk;

  seqtab_store u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_seq(eng_seq),
    .eng_word(eng_word), .eng_data(eng_data));

  function automatic logic [9:0] waddr(int s, int w);
    return 10'(10'h100 + 16*s + 4*w);
  endfunction

  function automatic logic [31:0] reset_val(int i);
    case (i)
      0: return 32'h0818_0403;
      1: return 32'h0000_1C08;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic [9:0] a, logic [31:0] d);
    if (a == KADR) m_armed = (d == KEY);
    else begin
      if (a == CADR && m_armed) begin
        if (d[1:0] == 2'b01) m_locked = 1'b1;
        if (d[1:0] == 2'b10) m_locked = 1'b0;
      end
      if (a >= 10'h100 && a[1:0] == 2'b00 && !m_locked) mdl[(a - 10'h100) >> 2] = d;
      m_armed = 1'b0;
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_lock(string req, logic exp);
    logic [31:0] d;
    rd(CADR, d);
    check(req, d, {31'b0, exp});
  endtask

  task automatic chk_word(string req, int s, int w);
    logic [31:0] d;
    rd(waddr(s, w), d);
    eng_seq = 4'(s); eng_word = 2'(w);
    #1;
    check(req, d, mdl[s*4+w]);
    check(req, eng_data, mdl[s*4+w]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mdl[i] = reset_val(i);
    m_locked = 1'b1; m_armed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents and lock
    chk_lock("R1", 1'b1);
    for (int i = 0; i < 64; i++) chk_word("R1", i / 4, i % 4);

    // R3 locked writes dropped
    wr(waddr(0, 0), 32'hDEAD_BEEF);
    wr(waddr(7, 3), 32'h1234_5678);
    chk_word("R3", 0, 0); chk_word("R3", 7, 3);

    // R7 command without key
    wr(CADR, 32'h2);
    chk_lock("R7", 1'b1);

    // R5 unlock handshake, R4 writes land
    wr(KADR, KEY); wr(CADR, 32'h2);
    chk_lock("R5", 1'b0);
    wr(waddr(5, 2), 32'hCAFE_0001);
    wr(waddr(15, 3), 32'hFFFF_0000);
    chk_word("R4", 5, 2); chk_word("R4", 5, 1); chk_word("R4", 15, 3); chk_word("R2", 15, 2);

    // R8 both bits / neither bit
    wr(KADR, KEY); wr(CADR, 32'h3);
    chk_lock("R8", 1'b0);
    wr(KADR, KEY); wr(CADR, 32'h0);
    chk_lock("R8", 1'b0);

    // R7 intervening table write disarms; reads between do not
    wr(KADR, KEY); wr(waddr(1, 1), 32'h0000_00AA); wr(CADR, 32'h1);
    chk_lock("R7", 1'b0);
    wr(KADR, KEY);
    rd(waddr(1, 1), d); rd(KADR, d);
    check("R9", d, 32'h0);
    wr(CADR, 32'h1);
    chk_lock("R6", 1'b1);

    // R7 wrong key, R9 unmapped read
    wr(KADR, KEY ^ 32'h1); wr(CADR, 32'h2);
    chk_lock("R7", 1'b1);
    rd(10'h044, d);
    check("R9", d, 32'h0);

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int op = int'($urandom_range(0, 9));
      int s = int'($urandom_range(0, 15));
      int w = int'($urandom_range(0, 3));
      case (op)
        0, 1: wr(KADR, ($urandom_range(0, 3) != 0) ? KEY : $urandom());
        2, 3: wr(CADR, {$urandom_range(0, 255), 2'(op == 2 ? 2'b10 : $urandom_range(0, 3))});
        4, 5, 6: wr(waddr(s, w), $urandom());
        7: chk_lock("R9", m_locked);
        default: chk_word("R2", s, w);
      endcase
    end
    for (int i = 0; i < 64; i++) chk_word("R4", i / 4, i % 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule